// File: doc/BRIEF.md
# Serial Floating-Point Exponent Aligner

This unit prepares two floating-point-style words for a later mantissa add or subtract. Each word holds an exponent field in its upper part and a fraction field in its lower part. The unit adds the fixed bias to both exponents and compares the results. It then makes the two exponents equal by moving the fraction of the smaller-exponent operand one bit to the right on each clock. Every such move also raises that operand's exponent by one. There is no wide combinational shifter: the cost is one register per field and a small down-counter.

A client drives both words and pulses `start` while the unit is idle. The unit reports `busy` while it works. It then raises `done` for exactly one cycle. In that cycle the two aligned fractions and the shared exponent are valid. When the exponents already match, the operands go straight through and no shift cycle is spent. Normalisation, rounding and special values belong to downstream logic.

Top module: `fpal_aligner`

## Requirements
- R1: Bits [31:24] of each word are its raw exponent and bits [23:0] are its fraction. The biased exponent is the raw exponent plus 127, kept to 8 bits (modulo 256). In the `done` cycle, `exp_o` equals the larger of the two biased exponents.
- R2: In the `done` cycle, the fraction of the operand with the smaller biased exponent equals its input fraction shifted right, with zero fill, by the difference between the two biased exponents. A difference of 24 or more gives zero.
- R3: In the `done` cycle, the fraction of the operand with the larger biased exponent equals its input fraction, unchanged.
- R4: If `start` is sampled at a rising edge while the unit is idle, and d is the exponent difference, then `done` is high in the cycle that begins d+1 rising edges after that sampling edge. `busy` is high from the cycle after that edge up to and including the `done` cycle. This holds for d up to 255.
- R5: When both biased exponents are equal, `done` comes in the cycle right after start is accepted, and both fractions are unchanged.
- R6: `done` lasts exactly one cycle. In the next cycle, both `done` and `busy` are low.
- R7: A `start` pulse, or a change of the operand words, while `busy` is high has no effect on the result of the operation in flight and starts no new operation.
- R8: While synchronous active-high reset is asserted, and in the cycle after it is released, `busy` and `done` are low, even if `start` is high during reset.
- R9: The comparison uses the wrapped biased values. For example, raw exponents 0x80 and 0x81 bias to 255 and 0. The second operand is therefore the smaller one, with a difference of 255.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an alignment; accepted only when idle |
| opnd_a_i | input | 32 | First operand word |
| opnd_b_i | input | 32 | Second operand word |
| frac_a_o | output | 24 | Aligned fraction of the first operand |
| frac_b_o | output | 24 | Aligned fraction of the second operand |
| exp_o | output | 8 | Common biased exponent after alignment |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse: outputs valid |

## Verification
The operand pairs include equal exponents, a few small differences with the first operand smaller and with the second operand smaller, and differences of 23 and 24. The equal-exponent pair shows that the zero-shift path skips the count state. The two small-difference directions show that the shift goes to the correct lane. The 23 and 24 cases show that the last surviving fraction bit leaves at the correct count. Raw exponents whose biased values wrap, including the 255-step worst case, separate a wrapped comparison from a plain raw comparison and check the cycle-exact latency. A `start` pulse with altered operands is driven in the middle of an operation, and a start is held high through reset; these show whether a stray start can disturb the result or the state machine.

// File: rtl/fpal_pkg.sv
package fpal_pkg;

    parameter int EXP_W  = 8;
    parameter int FRAC_W = 24;
    parameter int WORD_W = EXP_W + FRAC_W;
    parameter int BIAS   = 127;
    parameter int LANES  = 2;

    typedef logic [EXP_W-1:0]  exp_t;
    typedef logic [FRAC_W-1:0] frac_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        exp_t  e;
        frac_t f;
    } opnd_t;

    typedef enum logic [1:0] {
        ST_LOAD  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_DONE  = 2'd2
    } st_e;

    typedef struct packed {
        logic a_small;
        exp_t gap;
    } cmp_t;

    function automatic exp_t add_bias(exp_t raw);
        return exp_t'(raw + exp_t'(BIAS));
    endfunction

    function automatic opnd_t split_word(word_t w);
        opnd_t o;
        o.e = add_bias(w[WORD_W-1:FRAC_W]);
        o.f = w[FRAC_W-1:0];
        return o;
    endfunction

    function automatic cmp_t compare_exp(exp_t ea, exp_t eb);
        cmp_t c;
        c.a_small = (ea < eb);
        c.gap     = c.a_small ? exp_t'(eb - ea) : exp_t'(ea - eb);
        return c;
    endfunction

endpackage

// File: rtl/fpal_lane.sv
module fpal_lane
    import fpal_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  opnd_t load_val,
    input  logic  shift,
    output opnd_t val
);

    always_ff @(posedge clk) begin
        if (rst) begin
            val <= '0;
        end else if (load) begin
            val <= load_val;
        end else if (shift) begin
            val.f <= val.f >> 1;
            val.e <= val.e + 1'b1;
        end else begin
            val <= val;
        end
    end

endmodule

// File: rtl/fpal_ctrl.sv
module fpal_ctrl
    import fpal_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  exp_t gap,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);

    st_e  state_q;
    exp_t cnt_q;

    assign load = (state_q == ST_LOAD) && start;
    assign step = (state_q == ST_SHIFT);
    assign busy = (state_q != ST_LOAD);
    assign done = (state_q == ST_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_LOAD;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_LOAD: begin
                    if (start) begin
                        cnt_q   <= gap;
                        state_q <= (gap == '0) ? ST_DONE : ST_SHIFT;
                    end else begin
                        cnt_q   <= '0;
                        state_q <= ST_LOAD;
                    end
                end
                ST_SHIFT: begin
                    cnt_q   <= cnt_q - 1'b1;
                    state_q <= (cnt_q == exp_t'(1)) ? ST_DONE : ST_SHIFT;
                end
                ST_DONE: begin
                    cnt_q   <= '0;
                    state_q <= ST_LOAD;
                end
                default: begin
                    cnt_q   <= '0;
                    state_q <= ST_LOAD;
                end
            endcase
        end
    end

    // R6: the valid pulse is a single cycle and the unit is idle afterwards
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    // R4: the counter steps down by one on every shift cycle
    assert_count_down_R4: assert property (@(posedge clk) disable iff (rst)
        (step && cnt_q != exp_t'(1)) |=> (step && cnt_q == exp_t'($past(cnt_q) - 1'b1)));

    // R4: no shift cycle runs with an empty counter
    assert_shift_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
        step |-> (cnt_q != '0));

    // R7: a start while busy does not restart the machine
    assert_start_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (step && start && cnt_q != exp_t'(1)) |=> step);

endmodule

// File: rtl/fpal_aligner.sv
module fpal_aligner
    import fpal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [WORD_W-1:0] opnd_a_i,
    input  logic [WORD_W-1:0] opnd_b_i,
    output logic [FRAC_W-1:0] frac_a_o,
    output logic [FRAC_W-1:0] frac_b_o,
    output logic [EXP_W-1:0]  exp_o,
    output logic              busy_o,
    output logic              done_o
);

    opnd_t ld_val [LANES];
    opnd_t lane_q [LANES];
    logic  lane_sh[LANES];
    cmp_t  cmp;
    logic  load, step, sel_a_q;

    assign ld_val[0] = split_word(opnd_a_i);
    assign ld_val[1] = split_word(opnd_b_i);
    assign cmp       = compare_exp(ld_val[0].e, ld_val[1].e);

    fpal_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .gap   (cmp.gap),
        .load  (load),
        .step  (step),
        .busy  (busy_o),
        .done  (done_o)
    );

    // Direction is latched once at load; exponents move during counting
    always_ff @(posedge clk) begin
        if (rst)       sel_a_q <= 1'b0;
        else if (load) sel_a_q <= cmp.a_small;
        else           sel_a_q <= sel_a_q;
    end

    assign lane_sh[0] = step &&  sel_a_q;
    assign lane_sh[1] = step && !sel_a_q;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        fpal_lane u_lane (
            .clk      (clk),
            .rst      (rst),
            .load     (load),
            .load_val (ld_val[i]),
            .shift    (lane_sh[i]),
            .val      (lane_q[i])
        );
    end

    assign frac_a_o = lane_q[0].f;
    assign frac_b_o = lane_q[1].f;
    assign exp_o    = sel_a_q ? lane_q[1].e : lane_q[0].e;

    // R1: both exponents agree when results are presented
    assert_exp_match_R1: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (lane_q[0].e == lane_q[1].e));

    // R3: the larger-exponent lane holds still while the other shifts
    assert_large_hold_R3: assert property (@(posedge clk) disable iff (rst)
        step |=> (sel_a_q ? $stable(lane_q[1]) : $stable(lane_q[0])));

    // R2: the smaller-exponent lane moves by exactly one bit per step
    assert_small_shift_R2: assert property (@(posedge clk) disable iff (rst)
        (step && sel_a_q) |=> (lane_q[0].f == ($past(lane_q[0].f) >> 1)));

endmodule

// File: tb/test_fpal_aligner.sv
module test_fpal_aligner;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] opnd_a_i = '0;
    logic [31:0] opnd_b_i = '0;
    logic [23:0] frac_a_o, frac_b_o;
    logic [7:0]  exp_o;
    logic        busy_o, done_o;

    fpal_aligner i_fpal_aligner (
        .clk(clk), .rst(rst), .start(start),
        .opnd_a_i(opnd_a_i), .opnd_b_i(opnd_b_i),
        .frac_a_o(frac_a_o), .frac_b_o(frac_b_o), .exp_o(exp_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    always #4 clk = ~clk;  // 125 MHz

    typedef struct {
        logic [23:0] fa;
        logic [23:0] fb;
        logic [7:0]  e;
        longint      lat;
        string       rq_a;
        string       rq_b;
    } item_t;

    item_t  sbq[$];
    int     errors = 0;
    int     checks = 0;
    longint cyc = 0;
    longint st_cyc = 0;
    bit     post_done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string rq, string what, longint act, longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, expv);
        end
    endtask

    function automatic logic [7:0] biased(logic [7:0] raw);
        return 8'((raw + 8'd127) % 256);
    endfunction

    // monitor: compares results as they appear
    always @(negedge clk) begin
        if (!rst) begin
            if (post_done) begin
                check(!done_o, "R6", "done after pulse", longint'(done_o), 0);
                check(!busy_o, "R6", "busy after pulse", longint'(busy_o), 0);
                post_done = 0;
            end
            if (done_o) begin
                if (sbq.size() == 0) begin
                    check(0, "R7", "unexpected done", 1, 0);
                end else begin
                    item_t it;
                    it = sbq.pop_front();
                    check(frac_a_o == it.fa, it.rq_a, "frac_a", longint'(frac_a_o), longint'(it.fa));
                    check(frac_b_o == it.fb, it.rq_b, "frac_b", longint'(frac_b_o), longint'(it.fb));
                    check(exp_o == it.e, "R1", "exp", longint'(exp_o), longint'(it.e));
                    check((cyc - st_cyc) == it.lat, "R4", "latency", cyc - st_cyc, it.lat);
                    check(busy_o, "R4", "busy at done", longint'(busy_o), 1);
                end
                post_done = 1;
            end
        end
    end

    // driver: pushes expectation, launches the operation, waits for it
    task automatic run_op(logic [31:0] a, logic [31:0] b, bit poke);
        item_t       it;
        logic [7:0]  ea, eb;
        int          d;
        ea = biased(a[31:24]);
        eb = biased(b[31:24]);
        d  = (ea > eb) ? int'(ea) - int'(eb) : int'(eb) - int'(ea);
        it.fa   = (ea < eb) ? 24'(a[23:0] >> d) : a[23:0];
        it.fb   = (eb < ea) ? 24'(b[23:0] >> d) : b[23:0];
        it.e    = (ea > eb) ? ea : eb;
        it.lat  = d + 1;
        it.rq_a = (d == 0) ? "R5" : ((ea < eb) ? "R2" : "R3");
        it.rq_b = (d == 0) ? "R5" : ((eb < ea) ? "R2" : "R3");
        sbq.push_back(it);
        @(negedge clk);
        st_cyc   = cyc;
        opnd_a_i = a;
        opnd_b_i = b;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (d > 0) check(busy_o, "R4", "busy after start", longint'(busy_o), 1);
        if (poke && d >= 3) begin
            opnd_a_i = 32'h01FFFFFF;
            opnd_b_i = 32'hFE000001;
            start    = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        do begin
            @(negedge clk); #1;
        end while (sbq.size() != 0);
        @(negedge clk); #1;
        check(!busy_o && !done_o, "R6", "idle after op", longint'({busy_o, done_o}), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R4 watchdog expired actual=%0d expected=done", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        start = 1'b1;  // R8: start held during reset
        repeat (3) @(negedge clk);
        check(!busy_o && !done_o, "R8", "state in reset", longint'({busy_o, done_o}), 0);
        start = 1'b0;
        rst   = 1'b0;
        @(negedge clk);
        check(!busy_o && !done_o, "R8", "state after reset", longint'({busy_o, done_o}), 0);

        run_op(32'h40123456, 32'h40ABCDEF, 0);  // R5 equal exponents
        run_op(32'h10F00F0F, 32'h13800001, 0);  // a smaller by 3
        run_op(32'h25FFFFFF, 32'h20A5A5A5, 0);  // b smaller by 5
        run_op(32'h30800000, 32'h47FFFFFF, 0);  // gap 23
        run_op(32'h30FFFFFF, 32'h48FFFFFF, 0);  // gap 24 -> zero
        run_op(32'h80ABCDEF, 32'h81FFFFFF, 0);  // R9 wrap, gap 255
        run_op(32'h82FFFFFF, 32'h7F123456, 0);  // R9 wrap, raw larger is smaller
        run_op(32'h50C0FFEE, 32'h54BEEF01, 1);  // R7 start poked while busy
        run_op(32'h00000001, 32'h00000002, 0);  // back-to-back equal
        run_op(32'hFF800000, 32'h00400000, 0);  // R9 mid-range wrap

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule